// File: doc/BRIEF.md
# Prime Number Seven-Segment Sequencer

This block cycles through a fixed list of the first thirty-two primes and presents the current one on three seven-segment digits at once. A free-running divider slows the fast system clock to a rate a person can read. Each time the divider's top bit goes from low to high, a five-bit index moves to the next table entry. The index wraps after the last entry, so the list repeats without end.

The table stores each prime as three packed decimal digits of four bits each. Its output therefore drives three digit decoders directly, and no binary-to-decimal conversion is needed. The current index is also brought out so it can be observed. The divider width is a parameter. A real board uses a 25-bit divider on a 100 MHz clock, while a simulation can use a short one.

Top module: `prime_disp_top`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, the divider and the index are cleared. After reset the index is 0 and the digits read 0, 0, 2.
- R2: The index increases by exactly one on the clock edge that follows each low-to-high change of the divider's top bit. That is one step every 2^PRE_W clock cycles. The first step comes 2^(PRE_W-1)+1 clock edges after the last edge at which reset was seen high.
- R3: Between two steps the index and all segment outputs stay constant.
- R4: Stepping from index 31 returns the index to 0, and the display again reads 002.
- R5: Table entry k holds the (k+1)-th prime, from 2 at index 0 to 131 at index 31. It is packed as decimal digits: bits [11:8] are hundreds, [7:4] are tens and [3:0] are units, each in the range 0 to 9.
- R6: Each segment bus is active-high with bit order {g,f,e,d,c,b,a}. The digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R7: The hundreds, tens and units outputs are all driven at the same time. A leading zero is shown as the pattern for 0 and is not blanked.
- R8: Raising reset in the middle of a sequence returns the index to 0. The first step after the reset again follows the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| segHund | output | 7 | Hundreds digit segments {g,f,e,d,c,b,a} |
| segTens | output | 7 | Tens digit segments {g,f,e,d,c,b,a} |
| segUnits | output | 7 | Units digit segments {g,f,e,d,c,b,a} |
| addr | output | 5 | Current table index |

## Verification
The bench builds the block with PRE_W = 4, so one step takes 16 clock cycles instead of about 33 million. At that rate a full pass over all 32 entries, the wrap from 31 back to 0, and a reset in the middle of the sequence all fit in a few hundred cycles. With the short divider the bench can also measure the exact spacing of the steps and the delay of the first step after reset, so the edge detector's timing is checked exactly rather than only on average.

// File: rtl/prime_disp_pkg.sv
package prime_disp_pkg;
  localparam int ADDR_W = 5;
  localparam int NIB_W  = 4;
  localparam int DIGITS = 3;
  localparam int WORD_W = NIB_W * DIGITS;
  localparam int SEG_W  = 7;

  typedef struct packed {
    logic clear;
    logic advance;
  } ctrlStrobes_t;

  // Packed-decimal prime table, hundreds in the top nibble.
  function automatic logic [WORD_W-1:0] primeWord(input logic [ADDR_W-1:0] idx);
    logic [WORD_W-1:0] w;
    case (idx)
      5'd0:  w = 12'h002;
      5'd1:  w = 12'h003;
      5'd2:  w = 12'h005;
      5'd3:  w = 12'h007;
      5'd4:  w = 12'h011;
      5'd5:  w = 12'h013;
      5'd6:  w = 12'h017;
      5'd7:  w = 12'h019;
      5'd8:  w = 12'h023;
      5'd9:  w = 12'h029;
      5'd10: w = 12'h031;
      5'd11: w = 12'h037;
      5'd12: w = 12'h041;
      5'd13: w = 12'h043;
      5'd14: w = 12'h047;
      5'd15: w = 12'h053;
      5'd16: w = 12'h059;
      5'd17: w = 12'h061;
      5'd18: w = 12'h067;
      5'd19: w = 12'h071;
      5'd20: w = 12'h073;
      5'd21: w = 12'h079;
      5'd22: w = 12'h083;
      5'd23: w = 12'h089;
      5'd24: w = 12'h097;
      5'd25: w = 12'h101;
      5'd26: w = 12'h103;
      5'd27: w = 12'h107;
      5'd28: w = 12'h109;
      5'd29: w = 12'h113;
      5'd30: w = 12'h127;
      default: w = 12'h131;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/prime_disp_seg.sv
module prime_disp_seg
  import prime_disp_pkg::*;
(
  input  logic [NIB_W-1:0] digit,
  output logic [SEG_W-1:0] seg
);
  always_comb begin
    case (digit)
      4'd0: seg = 7'h3F;
      4'd1: seg = 7'h06;
      4'd2: seg = 7'h5B;
      4'd3: seg = 7'h4F;
      4'd4: seg = 7'h66;
      4'd5: seg = 7'h6D;
      4'd6: seg = 7'h7D;
      4'd7: seg = 7'h07;
      4'd8: seg = 7'h7F;
      4'd9: seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end
endmodule

// File: rtl/prime_disp_ctrl.sv
module prime_disp_ctrl
  import prime_disp_pkg::*;
#(
  parameter int PRE_W = 25
) (
  input  logic         clk,
  input  logic         rst,
  output ctrlStrobes_t strobes
);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [PRE_W-1:0] preCnt;
  logic             msbQ;
  logic             msbRise;

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      msbQ   <= 1'b0;
    end else begin
      preCnt <= preCnt + PRE_ONE;
      msbQ   <= preCnt[PRE_W-1];
    end
  end

  assign msbRise         = preCnt[PRE_W-1] & ~msbQ;
  assign strobes.clear   = rst;
  assign strobes.advance = msbRise & ~rst;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |=> !strobes.advance); // R2

  AST_TICK_AFTER_RESET: assert property (@(posedge clk)
    rst |=> !strobes.advance); // R8
endmodule

// File: rtl/prime_disp_path.sv
module prime_disp_path
  import prime_disp_pkg::*;
(
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  output logic [ADDR_W-1:0] addr,
  output logic [SEG_W-1:0]  segAll [DIGITS]
);
  localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  logic [WORD_W-1:0] romWord;

  always_ff @(posedge clk) begin
    if (strobes.clear)        addr <= '0;
    else if (strobes.advance) addr <= addr + ADDR_ONE;
  end

  assign romWord = primeWord(addr);

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    prime_disp_seg uSeg (
      .digit(romWord[g*NIB_W +: NIB_W]),
      .seg  (segAll[g])
    );

    AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (strobes.clear)
      romWord[g*NIB_W +: NIB_W] <= NIB_W'(9)); // R5

    AST_DIGIT_LIT: assert property (@(posedge clk) disable iff (strobes.clear)
      segAll[g] != '0); // R7
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    strobes.clear |=> addr == '0); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.advance |=> addr == $past(addr) + ADDR_ONE); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.advance |=> $stable(addr)); // R3

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.advance && addr == ADDR_LAST) |=> addr == '0); // R4
endmodule

// File: rtl/prime_disp_top.sv
module prime_disp_top
  import prime_disp_pkg::*;
#(
  parameter int PRE_W = 25
) (
  input  logic         clk,
  input  logic         rst,
  output logic [6:0]   segHund,
  output logic [6:0]   segTens,
  output logic [6:0]   segUnits,
  output logic [4:0]   addr
);
  ctrlStrobes_t     strobes;
  logic [SEG_W-1:0] segAll [DIGITS];

  prime_disp_ctrl #(.PRE_W(PRE_W)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes)
  );

  prime_disp_path uPath (
    .clk    (clk),
    .strobes(strobes),
    .addr   (addr),
    .segAll (segAll)
  );

  assign segUnits = segAll[0];
  assign segTens  = segAll[1];
  assign segHund  = segAll[2];
endmodule

// File: tb/sim_prime_disp_top.sv
module sim_prime_disp_top;
  localparam int PRE_W  = 4;
  localparam int PERIOD = 1 << PRE_W;
  localparam int FIRST  = (1 << (PRE_W - 1)) + 1;

  // Reference segment patterns {g,f,e,d,c,b,a} for digits 0..9 (R6).
  localparam logic [6:0] SEG_REF [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                         7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] segHund, segTens, segUnits;
  logic [4:0] addr;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  prime_disp_top #(.PRE_W(PRE_W)) u0 (
    .clk(clk), .rst(rst), .segHund(segHund), .segTens(segTens),
    .segUnits(segUnits), .addr(addr)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  function automatic int nthPrime(input int k);
    int found = -1;
    int cand = 1;
    while (found < k) begin
      bit isP = 1;
      cand++;
      for (int d = 2; d * d <= cand; d++) if (cand % d == 0) isP = 0;
      if (isP) found++;
    end
    return cand;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic checkDisplay(input int idx, input string req);
    int p = nthPrime(idx);
    check(addr == 5'(idx), req, addr, idx);
    check(segHund  == SEG_REF[p / 100],      {req, "/R5/R7 hundreds"}, segHund,  SEG_REF[p / 100]);
    check(segTens  == SEG_REF[(p / 10) % 10], {req, "/R5/R6 tens"},    segTens,  SEG_REF[(p / 10) % 10]);
    check(segUnits == SEG_REF[p % 10],       {req, "/R5/R6 units"},    segUnits, SEG_REF[p % 10]);
  endtask

  // Count negedges until addr leaves its current value.
  task automatic waitStep(output int gap);
    logic [4:0] start = addr;
    gap = 0;
    while (addr == start && gap < 4 * PERIOD) begin
      @(negedge clk);
      gap++;
      if (addr == start) begin
        check(segUnits == SEG_REF[nthPrime(int'(start)) % 10], "R3 hold", segUnits,
              SEG_REF[nthPrime(int'(start)) % 10]);
      end
    end
  endtask

  initial begin
    int gap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    checkDisplay(0, "R1 reset");
    check(segHund == 7'h3F, "R7 leading zero", segHund, 7'h3F);

    // R2: first step delay
    waitStep(gap);
    check(gap == FIRST, "R2 first step", gap, FIRST);
    checkDisplay(1, "R2 after first");

    // Walk the table, vector by vector, through the wrap (R2, R4, R5, R6)
    for (int i = 2; i <= 33; i++) begin
      waitStep(gap);
      check(gap == PERIOD, "R2 period", gap, PERIOD);
      if (i == 32) checkDisplay(0, "R4 wrap");
      else checkDisplay(i % 32, "R5 table");
    end

    // R8: reset in the middle of the sequence
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    checkDisplay(0, "R8 mid reset");
    waitStep(gap);
    check(gap == FIRST, "R8 first step", gap, FIRST);
    checkDisplay(1, "R8 resume");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule